// File: doc/BRIEF.md
# Relative-Index Sparse Vector Encoder

The encoder takes one matrix column at a time as a stream of dense weight codes and produces a compressed stream. Only nonzero codes are stored. Each stored entry carries two fields. The first is a narrow relative index: the number of rows skipped since the previous stored entry. The second is the weight code itself. Code 0 is reserved to mean zero.

The index field has a limited range. When a run of zeros would overflow it, the encoder stores a filler entry with code 0, and the next gap is measured from that filler. A downstream decoder rebuilds absolute rows by adding (relative index + 1) for each entry, starting from row -1.

Both streams use valid/ready handshakes:
- An input beat is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- An output entry is consumed on a clock edge where `out_valid` and `out_ready` are both high.
- While an entry is held and not consumed, it stays unchanged and the input is refused.

When the last beat of a column is accepted, the block pulses the number of entries that column produced on a plain side output.

Top module: `relidx_sparse_enc`

## Requirements
- R1: An entry's `out_rel` equals the number of rows between it and the previous stored entry of the same column. The first entry of a column counts from a virtual row -1, so a nonzero code at row 0 gives `out_rel` = 0. `out_code` carries the input code unchanged.
- R2: A zero code (value 0) accepted while the current gap is below the all-ones index value (15 for the 4-bit default) produces no output entry.
- R3: A zero code accepted while the gap equals the all-ones index value emits a filler entry with `out_rel` = all-ones and `out_code` = 0. The gap then restarts from that filler's row. A gap of exactly the all-ones value needs no filler. This rule also applies on the last row of a column.
- R4: In the cycle after the last beat of a column (`in_last` = 1) is accepted, `cnt_valid` is high for exactly one cycle. In that cycle `cnt_value` holds the number of entries the column produced, fillers included.
- R5: The gap and the entry count restart at the column boundary. The next column's first entry counts from row -1 again.
- R6: While `out_valid` is high and `out_ready` is low, `out_rel` and `out_code` stay stable and `in_ready` is low. No entry is lost or duplicated.
- R7: After reset, `out_valid` and `cnt_valid` are low and `in_ready` is high.
- R8: Decoding the output stream by accumulating (`out_rel` + 1) from row -1, with all other rows zero, rebuilds the input column exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Dense code beat is offered |
| in_ready | output | 1 | Encoder can take a beat |
| in_code | input | CODE_W | Dense weight code; 0 is the zero code |
| in_last | input | 1 | Beat is the final row of the column |
| out_valid | output | 1 | An entry is held on the output |
| out_ready | input | 1 | Downstream takes the entry |
| out_rel | output | IDX_W | Rows skipped since the previous entry |
| out_code | output | CODE_W | Stored weight code (0 for a filler) |
| cnt_valid | output | 1 | One-cycle pulse at the end of a column |
| cnt_value | output | CNT_W | Entries in the finished column |

## Verification
Two events can fall in the same cycle: the column-end count pulse and the loading of that column's final entry. Both happen when the last beat is nonzero, or when the last beat is a zero that forces a filler. The bench provokes this by ending columns on such beats while `out_ready` toggles. It then checks that the count includes that final entry, and that the entry is still delivered once after the stall.

A second overlap is a filler decision made while the output is stalled. This is driven by long zero runs under back-pressure and judged by decoding the full stream against the input.

// File: rtl/relidx_pkg.sv
package relidx_pkg;
  typedef enum logic [1:0] {
    ACT_SKIP = 2'd0,
    ACT_DATA = 2'd1,
    ACT_FILL = 2'd2
  } enc_act_t;
endpackage

// File: rtl/relidx_gap_track.sv
module relidx_gap_track
  import relidx_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [CODE_W-1:0] code,
  input  logic              last,
  output enc_act_t          act,
  output logic [IDX_W-1:0]  rel
);
  localparam logic [IDX_W-1:0] GAP_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] gap_q;

  always_comb begin
    if (code != '0)          act = ACT_DATA;
    else if (gap_q == GAP_MAX) act = ACT_FILL;
    else                     act = ACT_SKIP;
  end

  assign rel = gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (step) begin
      if (last || act != ACT_SKIP) gap_q <= '0;
      else                         gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/relidx_out_stage.sv
module relidx_out_stage #(
  parameter int IDX_W  = 4,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IDX_W-1:0]  rel_in,
  input  logic [CODE_W-1:0] code_in,
  output logic              can_take,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_rel,
  output logic [CODE_W-1:0] out_code
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rel   <= '0;
      out_code  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_rel   <= rel_in;
      out_code  <= code_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/relidx_col_count.sv
module relidx_col_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             emit,
  input  logic             last,
  output logic             cnt_valid,
  output logic [CNT_W-1:0] cnt_value
);
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_nx;

  assign run_nx = emit ? run_q + 1'b1 : run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      cnt_valid <= 1'b0;
      cnt_value <= '0;
    end else begin
      cnt_valid <= step && last;
      if (step) begin
        if (last) begin
          cnt_value <= run_nx;
          run_q     <= '0;
        end else begin
          run_q <= run_nx;
        end
      end
    end
  end
endmodule

// File: rtl/relidx_sparse_enc.sv
module relidx_sparse_enc
  import relidx_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_rel,
  output logic [CODE_W-1:0] out_code,
  output logic              cnt_valid,
  output logic [CNT_W-1:0]  cnt_value
);
  enc_act_t         act;
  logic [IDX_W-1:0] gap_rel;
  logic             step;
  logic             emit;

  assign step = in_valid && in_ready;
  assign emit = (act != ACT_SKIP);

  relidx_gap_track #(.IDX_W(IDX_W), .CODE_W(CODE_W)) gap_i (
    .clk(clk), .rst_n(rst_n), .step(step), .code(in_code),
    .last(in_last), .act(act), .rel(gap_rel)
  );

  relidx_out_stage #(.IDX_W(IDX_W), .CODE_W(CODE_W)) ost_i (
    .clk(clk), .rst_n(rst_n), .load(step && emit),
    .rel_in(gap_rel), .code_in(in_code), .can_take(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_rel(out_rel), .out_code(out_code)
  );

  relidx_col_count #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .step(step), .emit(emit),
    .last(in_last), .cnt_valid(cnt_valid), .cnt_value(cnt_value)
  );
endmodule

// File: rtl/relidx_sparse_enc_chk.sv
module relidx_sparse_enc_chk #(
  parameter int IDX_W  = 4,
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CODE_W-1:0] in_code,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [IDX_W-1:0]  out_rel,
  input logic [CODE_W-1:0] out_code,
  input logic              cnt_valid,
  input logic [CNT_W-1:0]  cnt_value
);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rel) && $stable(out_code));

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R1
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_code != '0 |=> out_valid && out_code == $past(in_code));

  // R3
  filler_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_code == '0 |-> out_rel == {IDX_W{1'b1}});

  // R4
  cnt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid |-> $past(in_valid && in_ready && in_last));

  // R4
  cnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> cnt_valid);
endmodule

bind relidx_sparse_enc relidx_sparse_enc_chk #(
  .IDX_W(IDX_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
) chk_i (.*);

// File: tb/relidx_sparse_enc_test.sv
module relidx_sparse_enc_test;
  localparam int IDX_W  = 4;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 16;
  localparam int RMAX   = (1 << IDX_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [CODE_W-1:0] in_code = '0;
  logic in_last = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [IDX_W-1:0] out_rel;
  logic [CODE_W-1:0] out_code;
  logic cnt_valid;
  logic [CNT_W-1:0] cnt_value;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  int col [0:63];
  int exp_rel [0:63];
  int exp_code [0:63];
  int exp_n;
  int got_rel [0:63];
  int got_code [0:63];
  int got_n;
  int got_cnt;
  int stalls;

  relidx_sparse_enc #(.IDX_W(IDX_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_rel(out_rel), .out_code(out_code),
    .cnt_valid(cnt_valid), .cnt_value(cnt_value)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // expected entry list built from R1..R3
  task automatic build_expected(input int n);
    int gap = 0;
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      if (col[i] != 0) begin
        exp_rel[exp_n] = gap; exp_code[exp_n] = col[i]; exp_n++; gap = 0;
      end else if (gap == RMAX) begin
        exp_rel[exp_n] = RMAX; exp_code[exp_n] = 0; exp_n++; gap = 0;
      end else begin
        gap++;
      end
    end
  endtask

  function automatic bit pat(input int mode, input int k);
    case (mode)
      0: pat = 1'b1;
      1: pat = (k % 2) == 0;
      default: pat = (k % 3) != 1;
    endcase
  endfunction

  task automatic drive(input int n, input int vmode);
    int i = 0;
    int k = 0;
    while (i < n) begin
      @(negedge clk);
      in_valid = pat(vmode, k);
      in_code  = CODE_W'(col[i]);
      in_last  = (i == n - 1);
      k++;
      #2;
      if (in_valid && !in_ready) stalls++;
      if (in_valid && in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic collect(input int rmode);
    int k = 0;
    bit seen = 0;
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      out_ready = pat(rmode, k);
      k++;
      #1;
      if (cnt_valid) begin
        if (seen) check("R4", "second count pulse", 1, 0);
        seen = 1;
        got_cnt = int'(cnt_value);
      end
      if (out_ready && out_valid && got_n < 64) begin
        got_rel[got_n] = int'(out_rel);
        got_code[got_n] = int'(out_code);
        got_n++;
      end
      if (seen && (!out_valid || out_ready)) done = 1;
    end
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic run_col(input string req, input int n, input int vmode, input int rmode);
    int pos;
    int rebuilt [0:63];
    build_expected(n);
    got_n = 0; got_cnt = -1; stalls = 0;
    fork
      drive(n, vmode);
      collect(rmode);
    join
    check(req, "entry count on stream", got_n, exp_n);
    check("R4", "cnt_value", got_cnt, exp_n);
    for (int e = 0; e < exp_n && e < got_n; e++) begin
      check(req, $sformatf("rel of entry %0d", e), got_rel[e], exp_rel[e]);
      check(req, $sformatf("code of entry %0d", e), got_code[e], exp_code[e]);
    end
    for (int i = 0; i < 64; i++) rebuilt[i] = 0;
    pos = -1;
    for (int e = 0; e < got_n; e++) begin
      pos += got_rel[e] + 1;
      if (pos < 64) rebuilt[pos] = got_code[e];
    end
    check("R8", "last decoded row inside column", int'(pos < n), 1);
    for (int i = 0; i < n; i++)
      if (rebuilt[i] != col[i]) check("R8", $sformatf("decoded row %0d", i), rebuilt[i], col[i]);
  endtask

  task automatic t_reset;
    #1;
    check("R7", "out_valid after reset", int'(out_valid), 0);
    check("R7", "cnt_valid after reset", int'(cnt_valid), 0);
    check("R7", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_all_zero;
    for (int i = 0; i < 10; i++) col[i] = 0;
    run_col("R2", 10, 0, 0);
  endtask

  task automatic t_dense;
    for (int i = 0; i < 8; i++) col[i] = i + 1;
    run_col("R1", 8, 0, 0);
    check("R1", "row0 entry rel", got_rel[0], 0);
  endtask

  task automatic t_gap_exact;
    for (int i = 0; i < 16; i++) col[i] = 0;
    col[15] = 9;
    run_col("R3", 16, 0, 0);
    check("R3", "no filler at exact max gap", got_n, 1);
  endtask

  task automatic t_gap_over;
    for (int i = 0; i < 17; i++) col[i] = 0;
    col[16] = 4;
    run_col("R3", 17, 0, 0);
    check("R3", "filler code", got_code[0], 0);
    check("R3", "entry after filler rel", got_rel[1], 0);
  endtask

  task automatic t_long_gap;
    for (int i = 0; i < 41; i++) col[i] = 0;
    col[40] = 12;
    run_col("R3", 41, 1, 2);
    check("R3", "fillers plus data", got_n, 3);
    check("R3", "final rel after two fillers", got_rel[2], 8);
  endtask

  task automatic t_backpressure;
    for (int i = 0; i < 48; i++) col[i] = ((i * 5) % 7 == 0) ? ((i % 15) + 1) : 0;
    col[47] = 6;
    run_col("R6", 48, 0, 1);
    check("R6", "input stalled at least once", int'(stalls > 0), 1);
    for (int i = 0; i < 60; i++) col[i] = (i % 4 == 3) ? 2 : ((i > 20 && i < 45) ? 0 : (i % 3));
    run_col("R6", 60, 2, 2);
  endtask

  task automatic t_boundary;
    for (int i = 0; i < 7; i++) col[i] = 0;
    col[2] = 5;
    run_col("R5", 7, 0, 0);
    col[0] = 3; col[1] = 0; col[2] = 0; col[3] = 1;
    run_col("R5", 4, 0, 1);
    check("R5", "next column first rel", got_rel[0], 0);
    check("R5", "next column second rel", got_rel[1], 2);
  endtask

  task automatic t_last_filler;
    for (int i = 0; i < 16; i++) col[i] = 0;
    run_col("R3", 16, 0, 2);
    check("R4", "filler on last row counted", got_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_all_zero();
    t_dense();
    t_gap_exact();
    t_gap_over();
    t_long_gap();
    t_backpressure();
    t_boundary();
    t_last_filler();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule